// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps the bookkeeping for data-speculative loads. A load that is hoisted above stores it might alias with records its destination register and the byte range it read. Every store, and every other agent that writes memory, presents its own byte range on a snoop port. Each recorded range that the write overlaps, even by one byte, is dropped. A later check names a register, and the block answers hit if that register's record is still present. A miss tells the pipeline that the speculated value is stale and must be reloaded or recovered.

The table is fully associative and keyed by destination register. A register has at most one record, and a new load to a register that already has one overwrites it. When the table is full and a new register needs a slot, the slots are reused in round-robin order. A load of the speculative-plus-advanced kind that took a deferred fault reports this on the allocate port, and it leaves no record for its register. A flush input empties the table. Check results appear one cycle after the request.

Top module: `spec_load_table`

## Requirements
- R1: After reset no entry is valid, so every check misses until an allocation has been made.
- R2: An allocation without fault records the register, start address and length. A check of that register in any later cycle, with no intervening overlapping write, returns chk_hit=1 on the cycle after the check is presented.
- R3: A snoop removes every valid entry whose range [start, start+len) intersects the snoop range. Both ranges are taken as 65-bit sums, so a range does not wrap past the top of the 64-bit space. Touching ranges that share no byte do not remove the entry.
- R4: The size code gives the access length in bytes: 0=1, 1=2, 2=4, 3=8, 4=10, and 5, 6 or 7 = 16. The same code is used on the allocate and snoop ports.
- R5: If a snoop and a check arrive in the same cycle, the snoop's removal is applied first, and the check sees the table without the removed entries.
- R6: An allocation to a register that already has a valid entry overwrites that entry in place. The old range then no longer affects checks of that register.
- R7: An allocation for a new register takes the lowest-numbered free slot. When no slot is free, it takes the slot named by a round-robin pointer. The pointer starts at 0 and advances by one, modulo the entry count, only on such a replacement.
- R8: A check with chk_consume=0 leaves a hit entry valid. A check with chk_consume=1 clears the entry it hits.
- R9: An allocation with alloc_fault=1 creates no entry and clears any entry already held for that register.
- R10: flush clears every entry in the cycle it is asserted. It overrides an allocation in the same cycle, and a check in that cycle returns miss.
- R11: chk_hit is 0 in every cycle that follows a cycle without chk_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| alloc_valid | input | 1 | Speculative load allocation request |
| alloc_reg | input | REG_W | Destination register of the load |
| alloc_addr | input | ADDR_W | Start byte address of the load |
| alloc_size | input | 3 | Size code of the load |
| alloc_fault | input | 1 | Load took a deferred fault; record nothing |
| snoop_valid | input | 1 | Memory write observed |
| snoop_addr | input | ADDR_W | Start byte address of the write |
| snoop_size | input | 3 | Size code of the write |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register being checked |
| chk_consume | input | 1 | Clear the entry on a hit |
| chk_hit | output | 1 | Registered check result |

## Verification
The bench uses the default parameters: 16 entries, 7-bit register tags and 64-bit addresses. With 16 entries the table fills within a few cycles, so round-robin replacement and the pointer's advance across fills can be checked directly. The full 64-bit address width lets the bench place a 16-byte range that ends exactly at the top of the address space and confirm that a write at address zero does not alias with it. A random phase with a narrow address window and eight registers then produces frequent partial overlaps, same-cycle snoop and check collisions, and reallocations. It compares every result against a behavioural model.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;

  typedef logic [2:0] size_code_t;
  typedef logic [4:0] byte_len_t;

  // Size code to access length in bytes; codes above 4 are 16-byte accesses
  function automatic byte_len_t code_to_len(size_code_t code);
    byte_len_t len;
    case (code)
      3'd0:    len = 5'd1;
      3'd1:    len = 5'd2;
      3'd2:    len = 5'd4;
      3'd3:    len = 5'd8;
      3'd4:    len = 5'd10;
      default: len = 5'd16;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/spec_slot_cmp.sv
module spec_slot_cmp
  import spec_load_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 7
) (
  input  logic              slot_valid,
  input  logic [REG_W-1:0]  slot_tag,
  input  logic [ADDR_W-1:0] slot_base,
  input  byte_len_t         slot_len,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_base,
  input  byte_len_t         wr_len,
  input  logic [REG_W-1:0]  probe_tag,
  input  logic [REG_W-1:0]  new_tag,
  output logic              wr_overlap,
  output logic              probe_eq,
  output logic              new_eq
);

  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] slot_lo, slot_hi, wr_lo, wr_hi;

  always_comb begin
    slot_lo    = {1'b0, slot_base};
    wr_lo      = {1'b0, wr_base};
    slot_hi    = slot_lo + EXT_W'(slot_len);
    wr_hi      = wr_lo + EXT_W'(wr_len);
    wr_overlap = slot_valid && wr_valid && (slot_lo < wr_hi) && (wr_lo < slot_hi);
    probe_eq   = (slot_tag == probe_tag);
    new_eq     = (slot_tag == new_tag);
  end

endmodule

// File: rtl/spec_slot_pick.sv
module spec_slot_pick #(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] free_vec,
  input  logic               take,
  output logic [ENTRIES-1:0] pick_oh
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PTR_W-1:0] rr_q, rr_d;
  logic             rr_en;
  logic [ENTRIES-1:0] low_free_oh;
  logic               any_free;

  always_comb begin
    low_free_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) low_free_oh = ENTRIES'(1) << i;
    end
    any_free = |free_vec;
    pick_oh  = any_free ? low_free_oh : (ENTRIES'(1) << rr_q);
    rr_en    = take && !any_free;
    rr_d     = (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

  // R7: the chosen slot is always a single slot
  p_pick_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(pick_oh));

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import spec_load_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 64,
  parameter int REG_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [2:0]        alloc_size,
  input  logic              alloc_fault,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [2:0]        snoop_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_consume,
  output logic              chk_hit
);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [REG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  base_q [ENTRIES];
  byte_len_t          len_q  [ENTRIES];

  logic [ENTRIES-1:0] snoop_kill, probe_eq, new_eq;
  logic [ENTRIES-1:0] live, probe_vec, consume_kill, post, same_reg;
  logic [ENTRIES-1:0] fault_clr, wr_oh, pick_oh;
  logic               good_alloc, need_slot, hit_now, hit_d;
  byte_len_t          snoop_len, alloc_len;

  assign snoop_len = code_to_len(snoop_size);
  assign alloc_len = code_to_len(alloc_size);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    spec_slot_cmp #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_cmp (
      .slot_valid (valid_q[g]),
      .slot_tag   (tag_q[g]),
      .slot_base  (base_q[g]),
      .slot_len   (len_q[g]),
      .wr_valid   (snoop_valid),
      .wr_base    (snoop_addr),
      .wr_len     (snoop_len),
      .probe_tag  (chk_reg),
      .new_tag    (alloc_reg),
      .wr_overlap (snoop_kill[g]),
      .probe_eq   (probe_eq[g]),
      .new_eq     (new_eq[g])
    );
  end

  spec_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .free_vec (~post),
    .take     (need_slot),
    .pick_oh  (pick_oh)
  );

  // Next state: snoop removal first, then the check, then allocation
  always_comb begin
    live         = valid_q & ~snoop_kill;
    probe_vec    = chk_valid ? (live & probe_eq) : '0;
    hit_now      = |probe_vec;
    consume_kill = chk_consume ? probe_vec : '0;
    post         = live & ~consume_kill;
    same_reg     = post & new_eq;
    good_alloc   = alloc_valid && !alloc_fault && !flush;
    need_slot    = good_alloc && !(|same_reg);
    fault_clr    = (alloc_valid && alloc_fault) ? same_reg : '0;
    wr_oh        = good_alloc ? ((|same_reg) ? same_reg : pick_oh) : '0;
    valid_d      = flush ? '0 : ((post & ~fault_clr) | wr_oh);
    hit_d        = hit_now && !flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      chk_hit <= 1'b0;
    end else begin
      valid_q <= valid_d;
      chk_hit <= hit_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (wr_oh[g]) begin
        tag_q[g]  <= alloc_reg;
        base_q[g] <= alloc_addr;
        len_q[g]  <= alloc_len;
      end
    end
  end

  // R11: a hit only follows a presented check
  p_hit_needs_check_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hit |-> $past(chk_valid));

  // R10: flush empties the table
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R6: a register never owns two live entries
  p_single_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> ($countones(valid_q & probe_eq) <= 1));

  // R2: a clean allocation leaves at least one valid entry
  p_alloc_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_fault && !flush) |=> (valid_q != '0));

  // R9: a faulted allocation writes no slot
  p_fault_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_fault) |-> (wr_oh == '0));

endmodule

// File: tb/tb_spec_load_table.sv
module tb_spec_load_table;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 16;
  localparam int ADDR_W     = 64;
  localparam int REG_W      = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flush;
  logic              alloc_valid, alloc_fault;
  logic [REG_W-1:0]  alloc_reg;
  logic [ADDR_W-1:0] alloc_addr;
  logic [2:0]        alloc_size;
  logic              snoop_valid;
  logic [ADDR_W-1:0] snoop_addr;
  logic [2:0]        snoop_size;
  logic              chk_valid, chk_consume;
  logic [REG_W-1:0]  chk_reg;
  logic              chk_hit;

  int n_cmp  = 0;
  int n_fail = 0;

  // Behavioural model
  bit          m_v [ENTRIES];
  int          m_t [ENTRIES];
  logic [64:0] m_lo [ENTRIES];
  logic [64:0] m_hi [ENTRIES];
  int          m_rr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
    .alloc_size(alloc_size), .alloc_fault(alloc_fault),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_size(snoop_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_consume(chk_consume),
    .chk_hit(chk_hit)
  );

  function automatic int len_of(logic [2:0] c);
    int l;
    case (c)
      3'd0: l = 1; 3'd1: l = 2; 3'd2: l = 4; 3'd3: l = 8; 3'd4: l = 10;
      default: l = 16;
    endcase
    return l;
  endfunction

  task automatic compare(logic got, logic exp, string req);
    n_cmp++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: chk_hit actual %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(bit av, int ar, logic [63:0] aa, logic [2:0] as_, bit af,
                      bit sv, logic [63:0] sa, logic [2:0] ss,
                      bit cv, int cr, bit cc, bit fl, string req);
    bit exp;
    int hit_idx;
    int same;
    int slot;
    logic [64:0] slo, shi;
    @(negedge clk);
    alloc_valid = av; alloc_reg = REG_W'(ar); alloc_addr = aa; alloc_size = as_;
    alloc_fault = af; snoop_valid = sv; snoop_addr = sa; snoop_size = ss;
    chk_valid = cv; chk_reg = REG_W'(cr); chk_consume = cc; flush = fl;
    // snoop removal
    if (sv) begin
      slo = {1'b0, sa};
      shi = slo + 65'(len_of(ss));
      for (int i = 0; i < ENTRIES; i++)
        if (m_v[i] && m_lo[i] < shi && slo < m_hi[i]) m_v[i] = 0;
    end
    // check
    hit_idx = -1;
    for (int i = 0; i < ENTRIES; i++) if (cv && m_v[i] && m_t[i] == cr) hit_idx = i;
    exp = (hit_idx >= 0) && !fl;
    if (hit_idx >= 0 && cc) m_v[hit_idx] = 0;
    // allocation
    if (fl) begin
      for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
    end else if (av) begin
      same = -1;
      for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_t[i] == ar) same = i;
      if (af) begin
        if (same >= 0) m_v[same] = 0;
      end else begin
        slot = same;
        if (slot < 0) begin
          for (int i = ENTRIES - 1; i >= 0; i--) if (!m_v[i]) slot = i;
          if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % ENTRIES;
          end
        end
        m_v[slot] = 1; m_t[slot] = ar;
        m_lo[slot] = {1'b0, aa};
        m_hi[slot] = {1'b0, aa} + 65'(len_of(as_));
      end
    end
    @(posedge clk);
    #1;
    compare(chk_hit, exp, req);
  endtask

  task automatic alloc(int r, logic [63:0] a, logic [2:0] s, string req);
    step(1, r, a, s, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic check(int r, bit c, string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, r, c, 0, req);
  endtask
  task automatic snoop(logic [63:0] a, logic [2:0] s, string req);
    step(0, 0, 0, 0, 0, 1, a, s, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 0; alloc_valid = 0; alloc_reg = '0; alloc_addr = '0;
    alloc_size = '0; alloc_fault = 0; snoop_valid = 0; snoop_addr = '0;
    snoop_size = '0; chk_valid = 0; chk_reg = '0; chk_consume = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_t[i] = 0; m_lo[i] = '0; m_hi[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    compare(chk_hit, 1'b0, "R1");
    @(negedge clk) rst_n = 1'b1;

    check(5, 0, "R1");
    // R2 and R8 (plain check keeps entry)
    alloc(5, 64'h100, 3'd3, "R2");
    check(5, 0, "R2");
    check(5, 0, "R8");
    // R3: touching write keeps, partial overlap removes
    snoop(64'h108, 3'd0, "R3");
    check(5, 0, "R3");
    snoop(64'h107, 3'd1, "R3");
    check(5, 0, "R3");
    // R4: 10-byte code
    alloc(6, 64'h200, 3'd4, "R4");
    snoop(64'h209, 3'd0, "R4");
    check(6, 0, "R4");
    alloc(7, 64'h300, 3'd4, "R4");
    snoop(64'h30A, 3'd0, "R4");
    check(7, 0, "R4");
    alloc(15, 64'h700, 3'd7, "R4");
    snoop(64'h70F, 3'd0, "R4");
    check(15, 0, "R4");
    // R5: snoop and check together
    alloc(8, 64'h400, 3'd2, "R5");
    step(0, 0, 0, 0, 0, 1, 64'h402, 3'd0, 1, 8, 0, 0, "R5");
    // R6: reallocation overwrites
    alloc(9, 64'h500, 3'd3, "R6");
    alloc(9, 64'h600, 3'd3, "R6");
    snoop(64'h500, 3'd3, "R6");
    check(9, 0, "R6");
    // R8: consuming check
    alloc(10, 64'h800, 3'd3, "R8");
    check(10, 1, "R8");
    check(10, 0, "R8");
    // R9: faulted allocation
    alloc(11, 64'h900, 3'd3, "R9");
    step(1, 11, 64'h900, 3'd3, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    check(11, 0, "R9");
    step(1, 12, 64'hA00, 3'd3, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    check(12, 0, "R9");
    // R10: flush
    alloc(13, 64'hB00, 3'd3, "R10");
    step(1, 14, 64'hC00, 3'd3, 0, 0, 0, 0, 1, 13, 0, 1, "R10");
    check(13, 0, "R10");
    check(14, 0, "R10");
    // R3: range ending at the top of the space
    alloc(50, 64'hFFFF_FFFF_FFFF_FFF0, 3'd5, "R3");
    snoop(64'h0, 3'd5, "R3");
    check(50, 0, "R3");
    snoop(64'hFFFF_FFFF_FFFF_FFFF, 3'd0, "R3");
    check(50, 0, "R3");
    // R7: fill twice over and replace round-robin
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      for (int r = 0; r < ENTRIES; r++) alloc(20 + r, 64'h1000 + 64'(r * 32), 3'd3, "R7");
      alloc(60, 64'h4000, 3'd3, "R7");
      alloc(61, 64'h4100, 3'd3, "R7");
      for (int r = 0; r < ENTRIES; r++) check(20 + r, 0, "R7");
      check(60, 0, "R7");
      check(61, 0, "R7");
    end
    // R11: idle cycles
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 3) == 0, $urandom % 8, 64'($urandom % 64), 3'($urandom),
           ($urandom % 8) == 0,
           ($urandom % 3) == 0, 64'($urandom % 64), 3'($urandom),
           ($urandom % 2) == 0, $urandom % 8, ($urandom % 4) == 0,
           ($urandom % 200) == 0, "R3");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule